// File: doc/BRIEF.md
# Host Bus Byte-Order Adapter

This block sits between an external host CPU bus and an internal register and data path that always holds data in little-endian byte order. Two static configuration inputs choose the host byte order (little or big) and the host bus width (8 or 16 bits). The host reaches two ports: a command/status port, which carries 16-bit register values, and a data port, which carries a stream of memory bytes. The adapter places each host write into a 16-bit internal word with per-byte write enables. It drives each host read from the internal word using the same lane rules. Any host lane it does not drive reads as FFh.

The byte exchange is not the same on both ports. The command/status port exchanges bytes only for a big-endian host on an 8-bit bus, so a register value looks the same on both sides. The data port exchanges bytes only for a big-endian host on a 16-bit bus, so a byte stream keeps its order. Writes pass through one register stage and come out as a single-cycle internal write strobe. Reads are purely combinational from the read controls and the internal word. A configuration input selects a variant in which a data-port byte read on a 16-bit bus drives the whole word.

Top module: `host_endian_adapter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, int_we is 0, int_wbe is 2'b00 and int_wdata is 0000h.
- R2: A word access (acc code 2'b00) on a 16-bit bus (cfg_bus8=0) writes with int_wbe=2'b11. int_wdata equals wr_hdata, except that the two bytes are exchanged on the data port (port code 1) when the host is big-endian. The command port (port code 0) never exchanges bytes on this path.
- R3: For a byte access on a 16-bit bus (acc 2'b01 = low byte, 2'b10 = high byte), the internal target byte is the upper byte (int_wbe=2'b10) for a big-endian low-byte access or a little-endian high-byte access. Otherwise the target is the lower byte (int_wbe=2'b01). The host lane that supplies the byte is the same lane as the target, except on the big-endian data port, where it is the opposite lane.
- R4: On an 8-bit bus, a byte access always takes its byte from wr_hdata[7:0]. The target is the lower internal byte for a low-byte access and the upper byte for a high-byte access, and the two are reversed on the big-endian command port.
- R5: There is no internal write (int_we=0, int_wbe=2'b00) after a cycle with wr_stb low, with acc code 2'b11, or with a word access on an 8-bit bus.
- R6: A write accepted at a clock edge shows int_we=1, int_port, int_wdata and int_wbe from that edge until the next one only. Bytes that are not enabled are 00h.
- R7: A word read on a 16-bit bus drives all of rd_hdata with rd_lane_en=2'b11. It returns int_rdata, with the bytes exchanged on the big-endian data port.
- R8: A byte read drives one host lane, chosen by the R3/R4 mapping, with the internal target byte. rd_lane_en is one-hot on that lane (bit 0 = rd_hdata[7:0]). The other lane reads FFh.
- R9: With cfg_data_wide=1, a data-port byte read on a 16-bit bus drives the full word exactly as in R7.
- R10: A read with acc code 2'b11, or a word read on an 8-bit bus, gives rd_hdata=FFFFh and rd_lane_en=2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_big_endian | input | 1 | 1 = big-endian host |
| cfg_bus8 | input | 1 | 1 = 8-bit host bus, 0 = 16-bit |
| cfg_data_wide | input | 1 | 1 = data-port byte reads drive the whole word on a 16-bit bus |
| wr_stb | input | 1 | Host write strobe |
| wr_port | input | 1 | 0 = command/status port, 1 = data port |
| wr_acc | input | 2 | 00 word, 01 low byte, 10 high byte, 11 reserved |
| wr_hdata | input | 16 | Host write data lanes |
| int_we | output | 1 | Internal write strobe |
| int_port | output | 1 | Port of the internal write |
| int_wdata | output | 16 | Internal little-endian write word |
| int_wbe | output | 2 | Internal byte enables, bit 1 = upper byte |
| rd_port | input | 1 | Read port select |
| rd_acc | input | 2 | Read access code, same encoding as wr_acc |
| int_rdata | input | 16 | Internal word of the selected port |
| rd_hdata | output | 16 | Host read data lanes |
| rd_lane_en | output | 2 | Host lanes driven, bit 0 = rd_hdata[7:0] |

## Verification
The hardest cases to reach are the big-endian byte accesses. There the host lane and the internal lane differ, and the difference depends on both the port and the bus width, so a mistake in one of the two swap conditions hides behind a symmetric pattern. The stimulus walks every mix of byte order, bus width, port, access code and wide-read option. It uses data whose two bytes always differ, so an exchanged or misrouted lane shows. Random vectors then mix these settings with idle cycles, which exposes strobes that stay high longer than one cycle.

// File: rtl/hbsa_pkg.sv
package hbsa_pkg;

    typedef enum logic [1:0] {
        ACC_WORD = 2'b00,
        ACC_LOW  = 2'b01,
        ACC_HIGH = 2'b10,
        ACC_RSVD = 2'b11
    } acc_e;

    typedef enum logic {
        PORT_CMD  = 1'b0,
        PORT_DATA = 1'b1
    } port_e;

    // Lane routing for one access
    typedef struct packed {
        logic valid;     // access moves data at all
        logic word;      // both lanes
        logic swap;      // bytes exchanged between host and internal
        logic int_lane;  // internal target byte for a byte access
        logic host_lane; // host lane carrying that byte
    } route_t;

endpackage

// File: rtl/hbsa_route_decode.sv
module hbsa_route_decode
    import hbsa_pkg::*;
(
    input  logic   big_endian,
    input  logic   bus8,
    input  logic   port,
    input  logic [1:0] acc,
    output route_t route
);
    logic is_hi;
    logic is_byte;
    logic swap_now;

    always_comb begin
        is_hi   = (acc == ACC_HIGH);
        is_byte = (acc == ACC_LOW) || (acc == ACC_HIGH);
        // command port keeps register values; data port keeps byte streams
        if (port == PORT_DATA) swap_now = big_endian & ~bus8;
        else                   swap_now = big_endian & bus8;

        route.swap  = swap_now;
        route.word  = (acc == ACC_WORD);
        route.valid = is_byte || ((acc == ACC_WORD) && !bus8);
        if (bus8) begin
            route.int_lane  = is_hi ^ swap_now;
            route.host_lane = 1'b0;
        end else begin
            route.int_lane  = is_hi ^ big_endian;
            route.host_lane = (is_hi ^ big_endian) ^ swap_now;
        end
    end
endmodule

// File: rtl/hbsa_wr_stage.sv
module hbsa_wr_stage
    import hbsa_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stb,
    input  logic                port,
    input  route_t              route,
    input  logic [2*BYTE_W-1:0] hdata,
    output logic                we,
    output logic                we_port,
    output logic [2*BYTE_W-1:0] wdata,
    output logic [1:0]          wbe
);
    localparam int LANES = 2;
    localparam int DW    = LANES * BYTE_W;

    logic [LANES-1:0][BYTE_W-1:0] h_lane;
    logic [LANES-1:0][BYTE_W-1:0] nxt_lane;
    logic [LANES-1:0]             nxt_be;
    logic                         take;

    assign h_lane = hdata;
    assign take   = stb & route.valid;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            nxt_lane[l] = '0;
            nxt_be[l]   = 1'b0;
            if (take) begin
                if (route.word) begin
                    nxt_be[l]   = 1'b1;
                    nxt_lane[l] = route.swap ? h_lane[LANES-1-l] : h_lane[l];
                end else if (route.int_lane == l[0]) begin
                    nxt_be[l]   = 1'b1;
                    nxt_lane[l] = h_lane[route.host_lane];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we      <= 1'b0;
            we_port <= 1'b0;
            wdata   <= '0;
            wbe     <= '0;
        end else begin
            we      <= take;
            we_port <= port;
            wdata   <= DW'(nxt_lane);
            wbe     <= nxt_be;
        end
    end
endmodule

// File: rtl/hbsa_rd_mux.sv
module hbsa_rd_mux
    import hbsa_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  route_t              route,
    input  logic                full_word,
    input  logic [2*BYTE_W-1:0] rdata,
    output logic [2*BYTE_W-1:0] hdata,
    output logic [1:0]          lane_en
);
    localparam int LANES = 2;
    localparam logic [BYTE_W-1:0] PULL = '1;

    logic [LANES-1:0][BYTE_W-1:0] r_lane;
    logic [LANES-1:0][BYTE_W-1:0] o_lane;

    assign r_lane = rdata;
    assign hdata  = o_lane;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            o_lane[l]  = PULL;
            lane_en[l] = 1'b0;
            if (route.valid) begin
                if (route.word || full_word) begin
                    lane_en[l] = 1'b1;
                    o_lane[l]  = route.swap ? r_lane[LANES-1-l] : r_lane[l];
                end else if (route.host_lane == l[0]) begin
                    lane_en[l] = 1'b1;
                    o_lane[l]  = r_lane[route.int_lane];
                end
            end
        end
    end
endmodule

// File: rtl/host_endian_adapter.sv
module host_endian_adapter
    import hbsa_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_big_endian,
    input  logic                cfg_bus8,
    input  logic                cfg_data_wide,
    input  logic                wr_stb,
    input  logic                wr_port,
    input  logic [1:0]          wr_acc,
    input  logic [2*BYTE_W-1:0] wr_hdata,
    output logic                int_we,
    output logic                int_port,
    output logic [2*BYTE_W-1:0] int_wdata,
    output logic [1:0]          int_wbe,
    input  logic                rd_port,
    input  logic [1:0]          rd_acc,
    input  logic [2*BYTE_W-1:0] int_rdata,
    output logic [2*BYTE_W-1:0] rd_hdata,
    output logic [1:0]          rd_lane_en
);
    route_t wr_route;
    route_t rd_route;
    logic   rd_full;

    hbsa_route_decode u_wr_dec (
        .big_endian (cfg_big_endian),
        .bus8       (cfg_bus8),
        .port       (wr_port),
        .acc        (wr_acc),
        .route      (wr_route)
    );

    hbsa_route_decode u_rd_dec (
        .big_endian (cfg_big_endian),
        .bus8       (cfg_bus8),
        .port       (rd_port),
        .acc        (rd_acc),
        .route      (rd_route)
    );

    hbsa_wr_stage #(.BYTE_W(BYTE_W)) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (wr_stb),
        .port    (wr_port),
        .route   (wr_route),
        .hdata   (wr_hdata),
        .we      (int_we),
        .we_port (int_port),
        .wdata   (int_wdata),
        .wbe     (int_wbe)
    );

    // whole-word variant for data-port byte reads on the wide bus
    assign rd_full = cfg_data_wide & (rd_port == PORT_DATA) & ~cfg_bus8;

    hbsa_rd_mux #(.BYTE_W(BYTE_W)) u_rd (
        .route     (rd_route),
        .full_word (rd_full),
        .rdata     (int_rdata),
        .hdata     (rd_hdata),
        .lane_en   (rd_lane_en)
    );
endmodule

// File: rtl/hbsa_checker.sv
module hbsa_checker #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_bus8,
    input logic                wr_stb,
    input logic                wr_port,
    input logic [2*BYTE_W-1:0] wr_hdata,
    input logic                int_we,
    input logic                int_port,
    input logic [2*BYTE_W-1:0] int_wdata,
    input logic [1:0]          int_wbe,
    input logic [2*BYTE_W-1:0] rd_hdata,
    input logic [1:0]          rd_lane_en
);
    localparam logic [BYTE_W-1:0] PULL = '1;

    p_we_from_stb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int_we |-> ($past(wr_stb) && int_port == $past(wr_port)));

    p_idle_no_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !int_we |-> (int_wbe == 2'b00 && int_wdata == '0));

    p_we_has_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int_we |-> (int_wbe != 2'b00));

    p_bus8_single_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (int_we && $past(cfg_bus8)) |-> ($countones(int_wbe) == 1));

    p_cmd_word_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (int_we && int_wbe == 2'b11 && !int_port) |-> (int_wdata == $past(wr_hdata)));

    p_low_pull_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_lane_en[0] |-> (rd_hdata[BYTE_W-1:0] == PULL));

    p_high_pull_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_lane_en[1] |-> (rd_hdata[2*BYTE_W-1:BYTE_W] == PULL));

    p_bus8_low_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bus8 |-> !rd_lane_en[1]);
endmodule

bind host_endian_adapter hbsa_checker #(.BYTE_W(BYTE_W)) u_hbsa_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_bus8   (cfg_bus8),
    .wr_stb     (wr_stb),
    .wr_port    (wr_port),
    .wr_hdata   (wr_hdata),
    .int_we     (int_we),
    .int_port   (int_port),
    .int_wdata  (int_wdata),
    .int_wbe    (int_wbe),
    .rd_hdata   (rd_hdata),
    .rd_lane_en (rd_lane_en)
);

// File: tb/host_endian_adapter_bench.sv
module host_endian_adapter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_big_endian = 1'b0, cfg_bus8 = 1'b0, cfg_data_wide = 1'b0;
    logic        wr_stb = 1'b0, wr_port = 1'b0;
    logic [1:0]  wr_acc = 2'b00;
    logic [15:0] wr_hdata = 16'h0;
    logic        int_we, int_port;
    logic [15:0] int_wdata;
    logic [1:0]  int_wbe;
    logic        rd_port = 1'b0;
    logic [1:0]  rd_acc = 2'b00;
    logic [15:0] int_rdata = 16'h0;
    logic [15:0] rd_hdata;
    logic [1:0]  rd_lane_en;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    host_endian_adapter u_host_endian_adapter (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // expected internal write: {we, be, data}
    function automatic logic [18:0] ref_wr(input logic stb, input logic big, input logic b8,
                                           input logic prt, input logic [1:0] acc, input logic [15:0] h);
        logic [1:0] be = 2'b00;
        logic [15:0] d = 16'h0;
        if (!stb || acc == 2'b11 || (b8 && acc == 2'b00)) return 19'h0;
        if (acc == 2'b00) begin
            be = 2'b11;
            d  = (prt && big) ? {h[7:0], h[15:8]} : h;
        end else if (!b8) begin
            if (!big) begin
                if (acc == 2'b01) begin be = 2'b01; d = {8'h00, h[7:0]}; end
                else              begin be = 2'b10; d = {h[15:8], 8'h00}; end
            end else if (!prt) begin
                if (acc == 2'b01) begin be = 2'b10; d = {h[15:8], 8'h00}; end
                else              begin be = 2'b01; d = {8'h00, h[7:0]}; end
            end else begin
                if (acc == 2'b01) begin be = 2'b10; d = {h[7:0], 8'h00}; end
                else              begin be = 2'b01; d = {8'h00, h[15:8]}; end
            end
        end else begin
            if ((acc == 2'b01) != (big && !prt)) begin be = 2'b01; d = {8'h00, h[7:0]}; end
            else                                 begin be = 2'b10; d = {h[7:0], 8'h00}; end
        end
        return {1'b1, be, d};
    endfunction

    // expected read: {lane_en, data}
    function automatic logic [17:0] ref_rd(input logic big, input logic b8, input logic wide,
                                           input logic prt, input logic [1:0] acc, input logic [15:0] r);
        logic [15:0] full = (prt && big) ? {r[7:0], r[15:8]} : r;
        if (acc == 2'b11 || (b8 && acc == 2'b00)) return {2'b00, 16'hFFFF};
        if (!b8 && (acc == 2'b00 || (wide && prt))) return {2'b11, full};
        if (b8) begin
            if ((acc == 2'b01) != (big && !prt)) return {2'b01, 8'hFF, r[7:0]};
            return {2'b01, 8'hFF, r[15:8]};
        end
        if (!big) return (acc == 2'b01) ? {2'b01, 8'hFF, r[7:0]} : {2'b10, r[15:8], 8'hFF};
        if (!prt) return (acc == 2'b01) ? {2'b10, r[15:8], 8'hFF} : {2'b01, 8'hFF, r[7:0]};
        return (acc == 2'b01) ? {2'b01, 8'hFF, r[15:8]} : {2'b10, r[7:0], 8'hFF};
    endfunction

    function automatic string wr_tag(input logic stb, input logic b8, input logic [1:0] acc);
        if (!stb || acc == 2'b11 || (b8 && acc == 2'b00)) return "R5";
        if (acc == 2'b00) return "R2";
        return b8 ? "R4" : "R3";
    endfunction

    function automatic string rd_tag(input logic b8, input logic wide, input logic prt, input logic [1:0] acc);
        if (acc == 2'b11 || (b8 && acc == 2'b00)) return "R10";
        if (acc == 2'b00) return "R7";
        if (wide && prt && !b8) return "R9";
        return "R8";
    endfunction

    task automatic do_write(input logic stb, input logic big, input logic b8,
                            input logic prt, input logic [1:0] acc, input logic [15:0] h);
        logic [18:0] e;
        @(negedge clk);
        cfg_big_endian = big; cfg_bus8 = b8;
        wr_stb = stb; wr_port = prt; wr_acc = acc; wr_hdata = h;
        e = ref_wr(stb, big, b8, prt, acc, h);
        @(negedge clk);
        chk(wr_tag(stb, b8, acc), {13'h0, int_we, int_wbe, int_wdata}, {13'h0, e});
        if (e[18]) chk("R6", {31'h0, int_port}, {31'h0, prt});
        wr_stb = 1'b0;
        @(negedge clk);
        chk("R6", {29'h0, int_we, int_wbe}, 32'h0);
    endtask

    task automatic do_read(input logic big, input logic b8, input logic wide,
                           input logic prt, input logic [1:0] acc, input logic [15:0] r);
        cfg_big_endian = big; cfg_bus8 = b8; cfg_data_wide = wide;
        rd_port = prt; rd_acc = acc; int_rdata = r;
        #1;
        chk(rd_tag(b8, wide, prt, acc), {14'h0, rd_lane_en, rd_hdata},
            {14'h0, ref_rd(big, b8, wide, prt, acc, r)});
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        int seed = 32'h5A17;
        void'($urandom(seed));
        // R1 reset state
        #1;
        chk("R1", {13'h0, int_we, int_wbe, int_wdata}, 32'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", {13'h0, int_we, int_wbe, int_wdata}, 32'h0);
        @(negedge clk);
        chk("R1", {13'h0, int_we, int_wbe, int_wdata}, 32'h0);

        // directed corner values
        do_write(1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 16'h5678); // R2: stored as 7856h
        do_write(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 16'h1234); // R2: unchanged
        do_write(1'b1, 1'b1, 1'b1, 1'b0, 2'b01, 16'hAB12); // R4: low byte -> upper lane
        do_write(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 16'hFFFF); // R5: no strobe

        // exhaustive mode sweep
        for (int m = 0; m < 64; m++) begin
            do_write(1'b1, m[0], m[1], m[2], m[4:3], 16'hC35A ^ {m[7:0], m[7:0]});
            do_read(m[0], m[1], m[5], m[2], m[4:3], 16'h9E21 ^ {m[7:0], 8'h00});
        end

        // constrained random
        for (int i = 0; i < 400; i++) begin
            logic [31:0] rv = $urandom;
            logic [15:0] dv = 16'($urandom);
            if (dv[15:8] == dv[7:0]) dv[15:8] = ~dv[7:0];
            do_write(rv[0] | rv[7], rv[1], rv[2], rv[3], rv[5:4], dv);
            do_read(rv[8], rv[9], rv[10], rv[11], rv[13:12], {dv[7:0], ~dv[15:8]});
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule